// File: doc/BRIEF.md
# Byte-Serial Instruction Fetch with Static Branch Prediction

This block sits at the front of a small 16-bit processor whose memory port is only one byte wide. Every instruction is two bytes. The block reads the even byte first, which holds instruction bits 7:0, and then the odd byte, which holds bits 15:8. Once it has both bytes it presents the assembled instruction to decode, along with the instruction's address and a flag saying whether the fetch stream went to a branch target. The program counter counts instructions, not bytes, so it is one bit narrower than the byte address. The memory byte address is the program counter with the half-select bit appended below it.

The next fetch address is chosen as soon as the second byte arrives. A dedicated adder adds the instruction's signed offset to its own address, and a small decoder recognises jumps and conditional branches. Jumps always follow the target. Conditional branches follow the target only when the offset is negative, meaning a backward branch. Everything else, including register-indirect jumps, continues sequentially. When execute finds that a prediction was wrong, or supplies an indirect target, it asserts a redirect. Fetch then drops any half-built instruction and restarts at the new address.

Top module: `ifu_fetch`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `inst_valid_o` is 0. Fetch starts at byte address 0, and the first instruction, which has address 0, is presented two cycles after reset is released.
- R2: Each instruction takes two consecutive byte reads: the even address (bits 7:0) and then the odd address (bits 15:8). `inst_valid_o` pulses for one cycle after the odd read, so it is never high in two consecutive cycles.
- R3: When `inst_valid_o` is high, `inst_o` holds the assembled instruction and `inst_pc_o` holds its instruction address, which is the byte address divided by 2.
- R4: The instruction encoding is as follows. Bits 15:12 are the opcode. Bits 8:0 are a two's-complement offset counted in instructions and taken relative to the instruction's own address. Opcode 0xC is jump-and-link, 0xD is plain jump, 0xE is branch-if-zero and 0xF is branch-if-nonzero.
- R5: For a conditional branch (0xE or 0xF) with a negative offset, `pred_taken_o` is 1 and the next fetch goes to the instruction's address plus the offset.
- R6: For a conditional branch with a zero or positive offset, `pred_taken_o` is 0 and the next fetch goes to the instruction's address plus 1.
- R7: For opcodes 0xC and 0xD, `pred_taken_o` is 1 whatever the sign of the offset, and the next fetch goes to the instruction's address plus the offset.
- R8: For every other opcode, including register-indirect jumps, `pred_taken_o` is 0 and fetch continues at the instruction's address plus 1.
- R9: In the cycle in which `inst_valid_o` is high, `mem_addr_o` already holds the even byte of the predicted next instruction, so there is no idle cycle between instructions.
- R10: When `redirect_i` is sampled high, the next cycle reads the even byte of `redirect_pc_i` and `inst_valid_o` is 0 in that cycle. A half-fetched instruction is discarded and never presented.
- R11: Target and sequential address arithmetic wraps modulo the instruction address space (2^15 instructions).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 16 | Byte address for the read port; bit 0 selects the half |
| mem_rdata_i | input | 8 | Read data, valid in the same cycle as the address |
| inst_valid_o | output | 1 | One-cycle pulse: an assembled instruction is available |
| inst_o | output | 16 | Assembled instruction |
| inst_pc_o | output | 15 | Instruction address of `inst_o` |
| pred_taken_o | output | 1 | Fetch followed the branch or jump target |
| redirect_i | input | 1 | Execute overrides the fetch address |
| redirect_pc_i | input | 15 | Instruction address to restart from |

## Verification
The assertions assume that the memory returns the byte for the current address combinationally in the same cycle. They also assume that `redirect_i` and `redirect_pc_i` change only away from the clock edge. The bench's memory model is a plain array indexed by `mem_addr_o`, and all of its inputs are driven on the falling edge, so both assumptions hold. Each test first places an instruction in the model memory and then reaches it through a redirect. This makes every fetch address and every prediction follow deterministically from the encoding in R4.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  localparam int unsigned INST_W = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned OP_W   = 4;

  localparam logic [OP_W-1:0] OP_JAL = 4'hC;
  localparam logic [OP_W-1:0] OP_JMP = 4'hD;
  localparam logic [OP_W-1:0] OP_BEZ = 4'hE;
  localparam logic [OP_W-1:0] OP_BNZ = 4'hF;

  typedef enum logic [1:0] {
    K_SEQ,
    K_JUMP,
    K_COND
  } ctl_kind_e;

  function automatic ctl_kind_e classify(input logic [OP_W-1:0] op);
    case (op)
      OP_JAL, OP_JMP: classify = K_JUMP;
      OP_BEZ, OP_BNZ: classify = K_COND;
      default:        classify = K_SEQ;
    endcase
  endfunction
endpackage

// File: rtl/ifu_branch_pred.sv
module ifu_branch_pred
  import ifu_pkg::*;
#(
  parameter int unsigned PC_W  = 15,
  parameter int unsigned IMM_W = 9
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic             taken_o,
  output logic [PC_W-1:0]  next_pc_o
);
  localparam int unsigned EXT_W = PC_W - IMM_W;

  ctl_kind_e       kind;
  logic [PC_W-1:0] offset;
  logic [PC_W-1:0] target;
  logic [PC_W-1:0] seq_pc;

  assign kind   = classify(op_i);
  assign offset = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
  // dedicated adder, independent of the execute ALU
  assign target = pc_i + offset;
  assign seq_pc = pc_i + PC_W'(1);

  always_comb begin
    case (kind)
      K_JUMP:  taken_o = 1'b1;
      K_COND:  taken_o = imm_i[IMM_W-1];
      default: taken_o = 1'b0;
    endcase
  end

  assign next_pc_o = taken_o ? target : seq_pc;
endmodule

// File: rtl/ifu_assembler.sv
module ifu_assembler
  import ifu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              hi_o,
  output logic              done_o,
  output logic [INST_W-1:0] word_o
);
  logic              hi_q;
  logic [BYTE_W-1:0] lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= 1'b0;
      lo_q <= '0;
    end else if (flush_i) begin
      hi_q <= 1'b0;
    end else begin
      hi_q <= ~hi_q;
      if (!hi_q) lo_q <= rdata_i;
    end
  end

  assign hi_o   = hi_q;
  assign done_o = hi_q & ~flush_i;
  assign word_o = {rdata_i, lo_q};

  // R2
  done_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/ifu_fetch.sv
module ifu_fetch
  import ifu_pkg::*;
#(
  parameter int unsigned PC_W  = 15,
  parameter int unsigned IMM_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [PC_W:0]     mem_addr_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              inst_valid_o,
  output logic [INST_W-1:0] inst_o,
  output logic [PC_W-1:0]   inst_pc_o,
  output logic              pred_taken_o,
  input  logic              redirect_i,
  input  logic [PC_W-1:0]   redirect_pc_i
);
  logic [PC_W-1:0]   pc_q;
  logic              hi;
  logic              done;
  logic [INST_W-1:0] word;
  logic              taken;
  logic [PC_W-1:0]   next_pc;

  ifu_assembler u_asm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (redirect_i),
    .rdata_i (mem_rdata_i),
    .hi_o    (hi),
    .done_o  (done),
    .word_o  (word)
  );

  ifu_branch_pred #(.PC_W(PC_W), .IMM_W(IMM_W)) u_pred (
    .pc_i      (pc_q),
    .op_i      (word[INST_W-1 -: OP_W]),
    .imm_i     (word[IMM_W-1:0]),
    .taken_o   (taken),
    .next_pc_o (next_pc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
    end else if (redirect_i) begin
      pc_q <= redirect_pc_i;
    end else if (done) begin
      pc_q <= next_pc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inst_valid_o <= 1'b0;
      inst_o       <= '0;
      inst_pc_o    <= '0;
      pred_taken_o <= 1'b0;
    end else begin
      inst_valid_o <= done;
      if (done) begin
        inst_o       <= word;
        inst_pc_o    <= pc_q;
        pred_taken_o <= taken;
      end
    end
  end

  assign mem_addr_o = {pc_q, hi};

  // R2
  byte_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_addr_o[0] && !redirect_i) |=> mem_addr_o[0] && $stable(mem_addr_o[PC_W:1]));

  // R9
  seq_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inst_valid_o && !pred_taken_o) |-> mem_addr_o == {inst_pc_o + PC_W'(1), 1'b0});

  // R10
  redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> (mem_addr_o == {$past(redirect_pc_i), 1'b0}) && !inst_valid_o);

  // R7
  jump_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inst_valid_o && inst_o[INST_W-1 -: 3] == 3'b110) |-> pred_taken_o);
endmodule

// File: tb/ifu_fetch_tb.sv
module ifu_fetch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        inst_valid;
  logic [15:0] inst;
  logic [14:0] inst_pc;
  logic        pred_taken;
  logic        redir = 1'b0;
  logic [14:0] redir_pc = '0;
  logic [7:0]  mem [0:511];
  int          nchk = 0;
  int          nerr = 0;

  always #5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[8:0]];

  ifu_fetch u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .mem_addr_o    (mem_addr),
    .mem_rdata_i   (mem_rdata),
    .inst_valid_o  (inst_valid),
    .inst_o        (inst),
    .inst_pc_o     (inst_pc),
    .pred_taken_o  (pred_taken),
    .redirect_i    (redir),
    .redirect_pc_i (redir_pc)
  );

  // {word pc, instruction, expected taken, expected next word pc}
  localparam logic [63:0] VEC [9] = '{
    {16'd20,  16'hE3FC, 16'd1, 16'd16},    // bez -4: backward taken
    {16'd30,  16'hF405, 16'd0, 16'd31},    // bnz +5: forward not taken
    {16'd40,  16'hC664, 16'd1, 16'd140},   // jal +100
    {16'd50,  16'hD1F6, 16'd1, 16'd40},    // jmp -10
    {16'd60,  16'h31FF, 16'd0, 16'd61},    // other opcode
    {16'd70,  16'hE000, 16'd0, 16'd71},    // zero offset
    {16'd80,  16'hF100, 16'd1, 16'd32592}, // -256 wraps (R11)
    {16'd90,  16'hD0FF, 16'd1, 16'd345},   // jmp +255
    {16'd100, 16'h9ABC, 16'd0, 16'd101}    // indirect: sequential
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] wpc, input logic [15:0] w);
    mem[{wpc, 1'b0}] = w[7:0];
    mem[{wpc, 1'b1}] = w[15:8];
  endtask

  task automatic redirect_to(input logic [14:0] p);
    @(negedge clk);
    redir = 1'b1;
    redir_pc = p;
    @(negedge clk);
    redir = 1'b0;
  endtask

  task automatic run_vec(input logic [63:0] v);
    logic [15:0] p, w, nx;
    logic        tk;
    string       tag;
    p  = v[63:48];
    w  = v[47:32];
    tk = v[16];
    nx = v[15:0];
    if (w[15:12] == 4'hC || w[15:12] == 4'hD) tag = "R7";
    else if (w[15:12] >= 4'hE) tag = tk ? "R5" : "R6";
    else tag = "R8";
    put(p[7:0], w);
    redirect_to(p[14:0]);
    chk("R10", {mem_addr, 15'd0, inst_valid}, {p[14:0], 1'b0, 15'd0, 1'b0});
    @(negedge clk);
    chk("R2", {mem_addr, 15'd0, inst_valid}, {p[14:0], 1'b1, 15'd0, 1'b0});
    @(negedge clk);
    chk("R2", {31'd0, inst_valid}, 32'd1);
    chk("R3", {16'd0, inst}, {16'd0, w});
    chk("R3", {17'd0, inst_pc}, {17'd0, p[14:0]});
    chk(tag, {31'd0, pred_taken}, {31'd0, tk});
    chk("R9", {17'd0, mem_addr[15:1]}, {17'd0, nx[14:0]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", {16'd0, mem_addr}, 32'd0);
    chk("R1", {31'd0, inst_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {15'd0, mem_addr, inst_valid}, {15'd0, 16'd1, 1'b0});
    @(negedge clk);
    chk("R1", {31'd0, inst_valid}, 32'd1);
    chk("R1", {17'd0, inst_pc}, 32'd0);
    chk("R8", {16'd0, mem_addr}, 32'd2);

    // table walk: R4 encodings, R5..R9, R11
    for (int k = 0; k < 9; k++) run_vec(VEC[k]);

    // R2: back-to-back sequential stream
    put(8'd150, 16'h1234);
    put(8'd151, 16'h5678);
    put(8'd152, 16'h0000);
    redirect_to(15'd150);
    repeat (2) @(negedge clk);
    chk("R2", {15'd0, inst_valid, inst}, {15'd0, 1'b1, 16'h1234});
    @(negedge clk);
    chk("R2", {31'd0, inst_valid}, 32'd0);
    @(negedge clk);
    chk("R2", {31'd0, inst_valid}, 32'd1);
    chk("R3", {17'd0, inst_pc}, 32'd151);
    chk("R3", {16'd0, inst}, 32'h5678);

    // R10: redirect while the odd byte is being read
    redirect_to(15'd150);
    @(negedge clk);
    chk("R10", {16'd0, mem_addr}, 32'd301);
    redir = 1'b1;
    redir_pc = 15'd100;
    @(negedge clk);
    redir = 1'b0;
    chk("R10", {15'd0, mem_addr, inst_valid}, {15'd0, 16'd200, 1'b0});
    @(negedge clk);
    chk("R10", {31'd0, inst_valid}, 32'd0);
    @(negedge clk);
    chk("R10", {31'd0, inst_valid}, 32'd1);
    chk("R10", {17'd0, inst_pc}, 32'd100);
    chk("R10", {16'd0, inst}, 32'h9ABC);

    // R5: backward branch is followed without a bubble
    put(8'd159, 16'h0000);
    put(8'd160, 16'hE1FF);
    redirect_to(15'd160);
    repeat (2) @(negedge clk);
    chk("R5", {30'd0, inst_valid, pred_taken}, 32'd3);
    chk("R5", {16'd0, mem_addr}, 32'd318);
    repeat (2) @(negedge clk);
    chk("R9", {31'd0, inst_valid}, 32'd1);
    chk("R9", {17'd0, inst_pc}, 32'd159);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule